// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog. Software writes a 32-bit mode register to choose a timeout from a coded 4-bit interval field and to set the enable bit. The 0-to-1 change of that enable bit loads a down-counter and starts it. After that, software must restart the counter through a control register before the count runs out. The counter steps once per half-second tick. A prescaler makes that tick from the system clock, and the clock frequency is a parameter, so a bench can use a tiny divide value.

When the count runs out, the block gives a one-cycle system-reset request. It does so only if the watchdog enable and a separate reset-enable bit are both set. A build-time parameter picks one of two register layouts. The open layout has two registers and accepts any restart. The keyed layout accepts a restart only when it carries a 12-bit key. It also has plain storage registers for interrupt enable, interrupt status and configuration, and the configuration register holds the reset-enable bit. Reads are combinational from the address. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `keyed_wdt`

## Requirements
- R1: After a synchronous reset, every register reads as zero, the watchdog is disabled and `rst_req` is low.
- R2: A reload loads the counter from the interval code. Codes 0 to 11 give 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32 half-second ticks, where one tick is CLK_HZ/TICK_HZ clock cycles. With both enables set, `rst_req` goes high exactly N*DIV cycles after the reload edge.
- R3: A mode write reloads the counter only when it takes bit 0 from 0 to 1. A mode write made while bit 0 is already 1 leaves the running count untouched.
- R4: A control write with bit 0 set reloads the counter from the stored interval code. In the open layout no key is needed.
- R5: In the keyed layout, a control write restarts the counter only if bits [12:1] of the written data equal 0xA57 and bit 0 is 1. Any other control write does nothing.
- R6: On expiry, `rst_req` is raised only if mode bit 0 is set and reset-enable is set. Reset-enable is mode bit 1 in the open layout and configuration bit 0 in the keyed layout.
- R7: `rst_req` is high for one cycle. The counter then stops and gives no further request until the next reload.
- R8: A reload requested with interval code 12 to 15 reuses the last valid reload count and sets a sticky error flag. Mode bit 31 reads that flag, and only reset clears it.
- R9: Reads of the control register and of unmapped addresses return zero. Writes to unmapped addresses change nothing.
- R10: Register offsets and field positions:
  - Open layout: control at 0x00, mode at 0x04, interval code in mode bits [6:3].
  - Keyed layout: interrupt enable at 0x00, interrupt status at 0x04, control at 0x10, configuration at 0x14, mode at 0x18, interval code in mode bits [7:4].
  - The interrupt and configuration registers read back what was written.
- R11: Mode bits [30:0] read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
Register reads are combinational, so each read is checked in the same low clock phase in which the address is driven. A reload happens at the edge that captures the write. The prescaler is cleared at that same edge, and the request register updates at the edge where the last tick lands. So the bench counts falling edges from the write edge and expects `rst_req` at exactly N*DIV falling edges. It then checks the next falling edge for the pulse to be low again. Checks that a request does not happen watch a window several tick periods longer than the timeout in force.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    typedef enum logic [0:0] {
        LAYOUT_OPEN  = 1'b0,
        LAYOUT_KEYED = 1'b1
    } layout_e;

    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned CODE_W   = 4;
    localparam int unsigned RELOAD_W = 6;
    localparam int unsigned KEY_W    = 12;
    localparam logic [KEY_W-1:0] RESTART_KEY = 12'hA57;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_MODE,
        SEL_CFG,
        SEL_IRQ_EN,
        SEL_IRQ_STA
    } reg_sel_e;

    typedef struct packed {
        logic                valid;
        logic [RELOAD_W-1:0] ticks;
    } interval_t;

    typedef struct packed {
        logic              req;
        logic [CODE_W-1:0] code;
    } reload_t;

    function automatic interval_t decode_interval(input logic [CODE_W-1:0] code);
        interval_t r;
        r.valid = 1'b1;
        case (code)
            4'd0:    r.ticks = 6'd1;
            4'd1:    r.ticks = 6'd2;
            4'd2:    r.ticks = 6'd4;
            4'd3:    r.ticks = 6'd6;
            4'd4:    r.ticks = 6'd8;
            4'd5:    r.ticks = 6'd10;
            4'd6:    r.ticks = 6'd12;
            4'd7:    r.ticks = 6'd16;
            4'd8:    r.ticks = 6'd20;
            4'd9:    r.ticks = 6'd24;
            4'd10:   r.ticks = 6'd28;
            4'd11:   r.ticks = 6'd32;
            default: begin
                r.valid = 1'b0;
                r.ticks = '0;
            end
        endcase
        return r;
    endfunction

    function automatic reg_sel_e decode_addr(input layout_e lay, input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (lay == LAYOUT_KEYED) begin
            case (a)
                8'h00:   s = SEL_IRQ_EN;
                8'h04:   s = SEL_IRQ_STA;
                8'h10:   s = SEL_CTRL;
                8'h14:   s = SEL_CFG;
                8'h18:   s = SEL_MODE;
                default: s = SEL_NONE;
            endcase
        end else begin
            case (a)
                8'h00:   s = SEL_CTRL;
                8'h04:   s = SEL_MODE;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int unsigned DIV = 12_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_spacing
            // R2: ticks are separated by the full divide period
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  reload_t reload,
    input  logic    wdog_en,
    input  logic    rst_en,
    output logic    rst_req,
    output logic    err
);
    interval_t           iv;
    logic [RELOAD_W-1:0] last_q;
    logic [RELOAD_W-1:0] cnt_q;
    logic [RELOAD_W-1:0] load_val;
    logic                run_q;
    logic                err_q;
    logic                pulse_q;

    always_comb begin
        iv       = decode_interval(reload.code);
        load_val = iv.valid ? iv.ticks : last_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            err_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (reload.req) begin
                cnt_q <= load_val;
                run_q <= (load_val != '0);
                if (iv.valid) begin
                    last_q <= iv.ticks;
                end else begin
                    err_q <= 1'b1;
                end
            end else if (run_q && tick) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == RELOAD_W'(1)) begin
                    run_q   <= 1'b0;
                    pulse_q <= wdog_en && rst_en;
                end
            end
        end
    end

    assign rst_req = pulse_q;
    assign err     = err_q;

    // R7: the request lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R6: a request follows a cycle with reset-enable set
    a_r6_needs_rst_en: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(rst_en) && $past(wdog_en));

    // R2: without a reload the count never grows
    a_r2_count_down_only: assert property (@(posedge clk) disable iff (rst)
        !reload.req |=> cnt_q <= $past(cnt_q));

    // R8: the error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter layout_e     LAYOUT = LAYOUT_KEYED,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              err,
    output logic [DATA_W-1:0] rdata,
    output reload_t           reload,
    output logic              wdog_en,
    output logic              rst_en
);
    localparam int unsigned INTV_LSB = (LAYOUT == LAYOUT_KEYED) ? 4 : 3;

    reg_sel_e          sel;
    logic [DATA_W-2:0] mode_q;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] irq_en_q;
    logic [DATA_W-1:0] irq_sta_q;
    logic              key_ok;
    logic              mode_wr;
    logic              ctrl_kick;
    logic              en_rise;

    generate
        if (LAYOUT == LAYOUT_KEYED) begin : g_keyed
            assign key_ok = (wdata[KEY_W:1] == RESTART_KEY);
            assign rst_en = cfg_q[0];
        end else begin : g_open
            assign key_ok = 1'b1;
            assign rst_en = mode_q[1];
        end
    endgenerate

    always_comb begin
        sel         = decode_addr(LAYOUT, addr);
        mode_wr     = wr_en && (sel == SEL_MODE);
        ctrl_kick   = wr_en && (sel == SEL_CTRL) && key_ok && wdata[0];
        en_rise     = mode_wr && wdata[0] && !mode_q[0];
        reload.req  = ctrl_kick || en_rise;
        reload.code = mode_wr ? wdata[INTV_LSB +: CODE_W] : mode_q[INTV_LSB +: CODE_W];
    end

    assign wdog_en = mode_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            cfg_q     <= '0;
            irq_en_q  <= '0;
            irq_sta_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE:    mode_q    <= wdata[DATA_W-2:0];
                SEL_CFG:     cfg_q     <= wdata;
                SEL_IRQ_EN:  irq_en_q  <= wdata;
                SEL_IRQ_STA: irq_sta_q <= wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE:    rdata = {err, mode_q};
            SEL_CFG:     rdata = cfg_q;
            SEL_IRQ_EN:  rdata = irq_en_q;
            SEL_IRQ_STA: rdata = irq_sta_q;
            default:     rdata = '0;
        endcase
    end

    // R9: control reads as zero
    a_r9_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |-> (rdata == '0));

    // R11: mode storage changes only through a mode write
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !mode_wr |=> mode_q == $past(mode_q));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter layout_e     LAYOUT  = LAYOUT_KEYED,
    parameter int unsigned CLK_HZ  = 24_000_000,
    parameter int unsigned TICK_HZ = 2,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

    reload_t reload;
    logic    tick;
    logic    wdog_en;
    logic    rst_en;
    logic    err;

    kwdt_regs #(.LAYOUT(LAYOUT), .DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .err     (err),
        .rdata   (rdata),
        .reload  (reload),
        .wdog_en (wdog_en),
        .rst_en  (rst_en)
    );

    kwdt_prescaler #(.DIV(DIV)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (reload.req),
        .tick (tick)
    );

    kwdt_counter cnt_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .reload  (reload),
        .wdog_en (wdog_en),
        .rst_en  (rst_en),
        .rst_req (rst_req),
        .err     (err)
    );

endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
    import kwdt_pkg::*;

    localparam int unsigned DIV = 4;

    // {interval code, ticks}
    localparam logic [9:0] VEC [0:11] = '{
        {4'd0, 6'd1},   {4'd1, 6'd2},   {4'd2, 6'd4},   {4'd3, 6'd6},
        {4'd4, 6'd8},   {4'd5, 6'd10},  {4'd6, 6'd12},  {4'd7, 6'd16},
        {4'd8, 6'd20},  {4'd9, 6'd24},  {4'd10, 6'd28}, {4'd11, 6'd32}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_a = 1'b0;
    logic        wr_b = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        rq_a, rq_b;
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    keyed_wdt #(.LAYOUT(LAYOUT_KEYED), .CLK_HZ(8), .TICK_HZ(2)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_b), .addr(addr), .wdata(wdata),
        .rdata(rdata_b), .rst_req(rq_b)
    );

    keyed_wdt #(.LAYOUT(LAYOUT_OPEN), .CLK_HZ(8), .TICK_HZ(2)) dut_a (
        .clk(clk), .rst(rst), .wr_en(wr_a), .addr(addr), .wdata(wdata),
        .rdata(rdata_a), .rst_req(rq_a)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        if (b) wr_b = 1'b1; else wr_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    task automatic rd(input bit b, input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = b ? rdata_b : rdata_a;
    endtask

    // counts falling edges until the request is seen; -1 if none
    task automatic wait_pulse(input bit b, input int limit, output int k, output logic wide);
        k    = -1;
        wide = 1'b0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if ((b ? rq_b : rq_a) === 1'b1) begin
                k = i;
                @(negedge clk);
                wide = b ? rq_b : rq_a;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int          k;
        logic        w;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(0, 8'h04, d); chk("R1 open mode", d, 32'h0);
        rd(1, 8'h18, d); chk("R1 keyed mode", d, 32'h0);
        rd(1, 8'h14, d); chk("R1 keyed cfg", d, 32'h0);
        rd(1, 8'h00, d); chk("R1 keyed irq_en", d, 32'h0);
        chk("R1 rst_req low", {30'b0, rq_b, rq_a}, 32'h0);

        // R2: table walk on the open layout, enable and reset-enable set
        for (int v = 0; v < 12; v++) begin
            wr(0, 8'h04, 32'h0);
            wr(0, 8'h04, (32'(VEC[v][9:6]) << 3) | 32'h3);
            wait_pulse(0, 200, k, w);
            chk($sformatf("R2 code %0d delay", VEC[v][9:6]), k, 32'(VEC[v][5:0]) * DIV);
            chk("R7 pulse width", {31'b0, w}, 32'h0);
        end

        // R7: no second request once expired
        wait_pulse(0, 40, k, w);
        chk("R7 stopped after expiry", k, 32'hFFFF_FFFF);

        // R3: second mode write with enable already set does not reload
        wr(0, 8'h04, 32'h0);
        wr(0, 8'h04, (32'd2 << 3) | 32'h3);
        repeat (5) @(negedge clk);
        wr(0, 8'h04, 32'h3);
        rd(0, 8'h04, d); chk("R11 mode readback", d, 32'h3);
        wait_pulse(0, 40, k, w);
        chk("R3 no reload while enabled", k, 32'd10);

        // R4: control restart without key on open layout, stored code 0 -> 1 tick
        wr(0, 8'h00, 32'h1);
        rd(0, 8'h00, d); chk("R9 open ctrl reads zero", d, 32'h0);
        wait_pulse(0, 40, k, w);
        chk("R4 open restart", k, 32'd4);

        // R6: open layout without reset-enable
        wr(0, 8'h04, 32'h0);
        wr(0, 8'h04, (32'd1 << 3) | 32'h1);
        wait_pulse(0, 30, k, w);
        chk("R6 open no rst_en", k, 32'hFFFF_FFFF);

        // R8: invalid code keeps last valid reload (2 ticks) and sets error
        wr(0, 8'h04, 32'h0);
        wr(0, 8'h04, (32'd1 << 3) | 32'h3);
        wait_pulse(0, 40, k, w);
        chk("R8 valid reload", k, 32'd8);
        rd(0, 8'h04, d); chk("R8 error clear", d[31], 32'h0);
        wr(0, 8'h04, 32'h0);
        wr(0, 8'h04, (32'd13 << 3) | 32'h3);
        wait_pulse(0, 40, k, w);
        chk("R8 invalid reuses last", k, 32'd8);
        rd(0, 8'h04, d); chk("R8 error set", d, 32'h8000_006B);
        wr(0, 8'h04, 32'h0);
        rd(0, 8'h04, d); chk("R8 error sticky", d, 32'h8000_0000);

        // R10: keyed layout storage registers
        wr(1, 8'h00, 32'h1234_5678);
        wr(1, 8'h04, 32'hCAFE_0001);
        rd(1, 8'h00, d); chk("R10 irq_en", d, 32'h1234_5678);
        rd(1, 8'h04, d); chk("R10 irq_sta", d, 32'hCAFE_0001);

        // R9: unmapped and control on keyed layout
        wr(1, 8'h0C, 32'hFFFF_FFFF);
        rd(1, 8'h0C, d); chk("R9 unmapped read", d, 32'h0);
        rd(1, 8'h18, d); chk("R9 unmapped write ignored mode", d, 32'h0);
        rd(1, 8'h14, d); chk("R9 unmapped write ignored cfg", d, 32'h0);
        rd(1, 8'h00, d); chk("R9 unmapped write ignored irq", d, 32'h1234_5678);

        // R6: keyed layout, cfg bit 0 clear -> no request
        wr(1, 8'h18, (32'd0 << 4) | 32'h1);
        rd(1, 8'h18, d); chk("R10 keyed mode readback", d, 32'h1);
        wait_pulse(1, 30, k, w);
        chk("R6 keyed no cfg rst_en", k, 32'hFFFF_FFFF);

        // R5: keyed restarts
        wr(1, 8'h14, 32'h1);
        rd(1, 8'h14, d); chk("R10 cfg readback", d, 32'h1);
        wr(1, 8'h10, 32'h1);
        wait_pulse(1, 30, k, w);
        chk("R5 missing key ignored", k, 32'hFFFF_FFFF);
        wr(1, 8'h10, 32'hA57 << 1);
        wait_pulse(1, 30, k, w);
        chk("R5 key without restart bit", k, 32'hFFFF_FFFF);
        wr(1, 8'h10, (32'hA57 << 1) | 32'h1);
        rd(1, 8'h10, d); chk("R9 keyed ctrl reads zero", d, 32'h0);
        wait_pulse(1, 30, k, w);
        chk("R5 keyed restart", k, 32'd4);
        chk("R7 keyed pulse width", {31'b0, w}, 32'h0);

        // R10: keyed interval field at bits [7:4]: code 2 -> 4 ticks
        wr(1, 8'h18, 32'h0);
        wr(1, 8'h18, (32'd2 << 4) | 32'h1);
        wait_pulse(1, 40, k, w);
        chk("R10 keyed interval field", k, 32'd16);

        // R1: reset clears everything again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(1, 8'h14, d); chk("R1 cfg after reset", d, 32'h0);
        rd(0, 8'h04, d); chk("R1 open mode after reset", d, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule